// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the arithmetic and logic stage of a small load-store integer core. In a single combinational pass it takes a first source operand, a second source operand, a 16-bit immediate, a 5-bit shift count and a 4-bit operation code. It returns a 32-bit result, an overflow flag and a gated register write enable.

A short front stage picks the second operand. It is either the register value or the immediate, widened by sign or by zeros according to the operation class. Behind it sit an adder/subtractor, a bitwise unit and a barrel shifter, and an output select chooses among them. Signed add and subtract check for two's-complement overflow. When that overflow occurs, the write enable is dropped so that the destination register keeps its old contents. The core's trap logic then takes the flag. The unsigned forms wrap silently.

Top module: `alu_exec_unit`

## Requirements
- R1: Operation codes are ADD=0, ADDU=1, SUB=2, SUBU=3, AND=4, OR=5, XOR=6, NOR=7, SLL=8, SRL=9, SRA=10, LUI=11. ADDU and SUBU return the sum or difference modulo 2^32 and never raise `ovf_o`.
- R2: ADD and SUB return the sum or difference modulo 2^32. They raise `ovf_o` exactly when the true signed result lies outside -2^31..2^31-1.
- R3: `wr_en_o` equals `wr_en_i` for every legal code without overflow. It is 0 whenever `ovf_o` is 1.
- R4: AND, OR, XOR and NOR return the bitwise function of `a_i` and the second operand. NOR is the inverted OR.
- R5: With `use_imm_i`=1, codes 0..3 use `imm_i` sign-extended to 32 bits as the second operand, and codes 4..7 use it zero-extended. With `use_imm_i`=0 they use `b_i`.
- R6: SLL, SRL and SRA shift `b_i` by `shamt_i` (0..31). SRL fills with zeros and SRA fills with bit 31 of `b_i`. `use_imm_i` has no effect on shifts.
- R7: LUI returns `imm_i` in bits 31:16 and zeros in bits 15:0, regardless of `use_imm_i`.
- R8: Codes 12..15 return a zero result with `ovf_o`=0 and `wr_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand / shift source |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | Select immediate as second operand |
| shamt_i | input | 5 | Shift count |
| wr_en_i | input | 1 | Requested register write enable |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow exception flag |
| wr_en_o | output | 1 | Gated register write enable |

## Verification
The block holds no state, so any fault in an internal select or carry path appears at `result_o`, `ovf_o` or `wr_en_o` in the same cycle the inputs are applied. The cases most likely to expose a wrong extension or a wrong overflow polarity are the sign boundaries: 0x7FFFFFFF plus one, 0x80000000 minus one, and an immediate of 0xFFFF. Shift faults show at counts 0, 1 and 31, and a negative source separates SRA from SRL. A gating fault shows as a write enable that stays high while the overflow flag is set.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10,
    OP_LUI  = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

  function automatic logic is_arith(input logic [OP_W-1:0] op);
    return op[3:2] == 2'b00;
  endfunction

  function automatic logic is_bitwise(input logic [OP_W-1:0] op);
    return op[3:2] == 2'b01;
  endfunction
endpackage

// File: rtl/alu_opnd_ext.sv
module alu_opnd_ext
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext;
  logic [DATA_W-1:0] imm_zext;

  assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign imm_zext = {{EXT_W{1'b0}}, imm_i};

  always_comb begin
    opnd_o = b_i;
    if (use_imm_i) begin
      if (is_arith(op_i)) begin
        opnd_o = imm_sext;
      end else if (is_bitwise(op_i)) begin
        opnd_o = imm_zext;
      end
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              trap_en_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              same_sign;
  logic              sign_flip;

  assign b_eff     = sub_i ? ~b_i : b_i;
  assign sum_o     = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
  assign same_sign = (a_i[MSB] == b_eff[MSB]);
  assign sign_flip = (sum_o[MSB] != a_i[MSB]);
  assign ovf_o     = trap_en_i & same_sign & sign_flip;
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        fn_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (logic_fn_e'(fn_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] src_rev;
  logic [DATA_W-1:0] stg_in;
  logic [DATA_W-1:0] stg [0:SH_W];
  logic [DATA_W-1:0] out_rev;
  logic              fill;

  // A left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign src_rev[i] = src_i[DATA_W-1-i];
    assign out_rev[i] = stg[SH_W][DATA_W-1-i];
  end

  assign stg_in = left_i ? src_rev : src_i;
  assign fill   = arith_i & ~left_i & src_i[DATA_W-1];
  assign stg[0] = stg_in;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned STEP = 2 ** k;
    assign stg[k+1] = amt_i[k]
      ? {{STEP{fill}}, stg[k][DATA_W-1:STEP]}
      : stg[k];
  end

  assign res_o = left_i ? out_rev : stg[SH_W];
endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned SH_W   = 5
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              wr_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o,
  output logic              wr_en_o
);
  localparam int unsigned LOW_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] bit_res;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] lui_res;
  logic              add_ovf;
  logic              legal;
  logic              sel_arith;
  logic              sel_bit;
  logic              sel_shift;

  alu_opnd_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .op_i      (op_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .opnd_o    (opnd_b)
  );

  // op bit 1 selects subtract, op bit 0 selects the unsigned (no trap) form.
  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i       (a_i),
    .b_i       (opnd_b),
    .sub_i     (op_i[1]),
    .trap_en_i (sel_arith & ~op_i[0]),
    .sum_o     (sum),
    .ovf_o     (add_ovf)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a_i   (a_i),
    .b_i   (opnd_b),
    .fn_i  (op_i[1:0]),
    .res_o (bit_res)
  );

  alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .src_i   (b_i),
    .amt_i   (shamt_i),
    .left_i  (op_i == OP_SLL),
    .arith_i (op_i == OP_SRA),
    .res_o   (sh_res)
  );

  assign lui_res   = {imm_i, {LOW_W{1'b0}}};
  assign sel_arith = is_arith(op_i);
  assign sel_bit   = is_bitwise(op_i);
  assign sel_shift = (op_i == OP_SLL) | (op_i == OP_SRL) | (op_i == OP_SRA);
  assign legal     = sel_arith | sel_bit | sel_shift | (op_i == OP_LUI);

  always_comb begin
    result_o = '0;
    if (sel_arith) begin
      result_o = sum;
    end else if (sel_bit) begin
      result_o = bit_res;
    end else if (sel_shift) begin
      result_o = sh_res;
    end else if (op_i == OP_LUI) begin
      result_o = lui_res;
    end
  end

  assign ovf_o   = add_ovf;
  assign wr_en_o = wr_en_i & legal & ~add_ovf;
endmodule

// File: rtl/alu_exec_unit_chk.sv
module alu_exec_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned SH_W   = 5
) (
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [SH_W-1:0]   shamt_i,
  input logic [DATA_W-1:0] result_o,
  input logic              ovf_o,
  input logic              wr_en_o
);
  localparam int unsigned LOW_W = DATA_W - IMM_W;

  always_comb begin
    if (ovf_o === 1'b1) begin
      assert_no_write_on_trap_R3: assert (wr_en_o == 1'b0);
    end
    if (op_i === 4'd1 || op_i === 4'd3) begin
      assert_unsigned_no_trap_R1: assert (ovf_o == 1'b0);
    end
    if (op_i === 4'd11) begin
      assert_upper_load_R7: assert (result_o == {imm_i, {LOW_W{1'b0}}});
    end
    if ((op_i === 4'd8 || op_i === 4'd9 || op_i === 4'd10) && shamt_i === '0) begin
      assert_zero_shift_R6: assert (result_o == b_i);
    end
    if (op_i === 4'd12 || op_i === 4'd13 || op_i === 4'd14 || op_i === 4'd15) begin
      assert_illegal_quiet_R8: assert (result_o == '0 && !ovf_o && !wr_en_o);
    end
    if (op_i[3:2] === 2'b11) begin
      assert_trap_only_addsub_R2: assert (ovf_o == 1'b0);
    end
  end
endmodule

bind alu_exec_unit alu_exec_unit_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)
) chk_i (
  .op_i     (op_i),
  .b_i      (b_i),
  .imm_i    (imm_i),
  .shamt_i  (shamt_i),
  .result_o (result_o),
  .ovf_o    (ovf_o),
  .wr_en_o  (wr_en_o)
);

// File: tb/alu_exec_unit_tb.sv
module alu_exec_unit_tb_top;
  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic        we;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        use_imm;
  logic [4:0]  shamt;
  logic        we_in;
  logic [31:0] res;
  logic        ovf;
  logic        we_out;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  alu_exec_unit dut_i (
    .op_i(op), .a_i(a), .b_i(b), .imm_i(imm), .use_imm_i(use_imm),
    .shamt_i(shamt), .wr_en_i(we_in),
    .result_o(res), .ovf_o(ovf), .wr_en_o(we_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic exp_t model(input logic [3:0] o, input logic [31:0] x,
                                 input logic [31:0] y, input logic [15:0] im,
                                 input logic ui, input logic [4:0] sh,
                                 input logic w, input string tag);
    exp_t e;
    logic [31:0] y2;
    longint sx, sy, st;
    e.tag = tag; e.ovf = 1'b0; e.res = 32'h0;
    y2 = y;
    if (ui && o <= 4'd3) y2 = {{16{im[15]}}, im};
    if (ui && o >= 4'd4 && o <= 4'd7) y2 = {16'h0, im};
    sx = longint'($signed(x)); sy = longint'($signed(y2));
    case (o)
      4'd0, 4'd1: begin e.res = x + y2; st = sx + sy;
                        if (o == 4'd0) e.ovf = (st > 64'sd2147483647) || (st < -64'sd2147483648); end
      4'd2, 4'd3: begin e.res = x - y2; st = sx - sy;
                        if (o == 4'd2) e.ovf = (st > 64'sd2147483647) || (st < -64'sd2147483648); end
      4'd4: e.res = x & y2;
      4'd5: e.res = x | y2;
      4'd6: e.res = x ^ y2;
      4'd7: e.res = ~(x | y2);
      4'd8: e.res = y << sh;
      4'd9: e.res = y >> sh;
      4'd10: e.res = $unsigned($signed(y) >>> sh);
      4'd11: e.res = {im, 16'h0};
      default: e.res = 32'h0;
    endcase
    e.we = (o <= 4'd11) ? (w & ~e.ovf) : 1'b0;
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [15:0] im, input logic ui, input logic [4:0] sh,
                       input logic w, input string tag);
    @(posedge clk); #1;
    op = o; a = x; b = y; imm = im; use_imm = ui; shamt = sh; we_in = w;
    exp_q.push_back(model(o, x, y, im, ui, sh, w, tag));
  endtask

  // Monitor: compares at the falling edge, half a period after the drive.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (res !== e.res || ovf !== e.ovf || we_out !== e.we) begin
          fails++;
          $display("FAIL %s: got res=%h ovf=%b we=%b exp res=%h ovf=%b we=%b",
                   e.tag, res, ovf, we_out, e.res, e.ovf, e.we);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0;
    op = 4'd15; a = '0; b = '0; imm = '0; use_imm = 1'b0; shamt = '0; we_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(4'd15, 32'h0, 32'h0, 16'h0, 0, 5'd0, 0, "R8 idle state");
    // R1 unsigned wrap
    drive(4'd1, 32'h7fffffff, 32'h1, 16'h0, 0, 0, 1, "R1 addu no trap");
    drive(4'd1, 32'hffffffff, 32'h1, 16'h0, 0, 0, 1, "R1 addu wrap");
    drive(4'd3, 32'h0, 32'h1, 16'h0, 0, 0, 1, "R1 subu wrap");
    drive(4'd3, 32'h80000000, 32'h1, 16'h0, 0, 0, 1, "R1 subu no trap");
    // R2 / R3 signed overflow and gating
    drive(4'd0, 32'd1, 32'd2, 16'h0, 0, 0, 1, "R2 add small");
    drive(4'd0, 32'h7fffffff, 32'h1, 16'h0, 0, 0, 1, "R3 add pos ovf");
    drive(4'd0, 32'h80000000, 32'h80000000, 16'h0, 0, 0, 1, "R3 add neg ovf");
    drive(4'd0, 32'hffffffff, 32'h1, 16'h0, 0, 0, 1, "R2 add mixed sign");
    drive(4'd2, 32'h80000000, 32'h1, 16'h0, 0, 0, 1, "R3 sub ovf");
    drive(4'd2, 32'h7fffffff, 32'hffffffff, 16'h0, 0, 0, 1, "R3 sub ovf neg b");
    drive(4'd2, 32'd5, 32'd7, 16'h0, 0, 0, 1, "R2 sub negative");
    drive(4'd0, 32'h7fffffff, 32'h1, 16'h0, 0, 0, 0, "R3 ovf with we low");
    // R5 immediate extension
    drive(4'd0, 32'd10, 32'h0, 16'hffff, 1, 0, 1, "R5 addi sext");
    drive(4'd0, 32'h7fff0000, 32'h0, 16'h8000, 1, 0, 1, "R5 addi sext neg");
    drive(4'd0, 32'h7fffffff, 32'h0, 16'h0001, 1, 0, 1, "R5 addi ovf");
    drive(4'd4, 32'hdeadbeef, 32'h0, 16'hffff, 1, 0, 1, "R5 andi zext");
    drive(4'd5, 32'h12340000, 32'hffffffff, 16'h8001, 1, 0, 1, "R5 ori zext");
    drive(4'd6, 32'hffffffff, 32'h0, 16'h00ff, 1, 0, 1, "R5 xori zext");
    // R4 bitwise
    drive(4'd4, 32'hf0f0f0f0, 32'hff00ff00, 16'h0, 0, 0, 1, "R4 and");
    drive(4'd5, 32'hf0f0f0f0, 32'h0f0f0000, 16'h0, 0, 0, 1, "R4 or");
    drive(4'd6, 32'haaaa5555, 32'hffff0000, 16'h0, 0, 0, 1, "R4 xor");
    drive(4'd7, 32'hf0000000, 32'h0000000f, 16'h0, 0, 0, 1, "R4 nor");
    // R6 shifts
    drive(4'd8, 32'h0, 32'h80000001, 16'h0, 0, 5'd0, 1, "R6 sll 0");
    drive(4'd8, 32'h0, 32'h80000001, 16'h0, 0, 5'd1, 1, "R6 sll 1");
    drive(4'd8, 32'h0, 32'h00000001, 16'h0, 0, 5'd31, 1, "R6 sll 31");
    drive(4'd9, 32'h0, 32'h80000000, 16'h0, 0, 5'd31, 1, "R6 srl 31");
    drive(4'd10, 32'h0, 32'h80000000, 16'h0, 0, 5'd31, 1, "R6 sra 31");
    drive(4'd10, 32'h0, 32'hf0000010, 16'h0, 0, 5'd4, 1, "R6 sra neg");
    drive(4'd10, 32'h0, 32'h70000010, 16'h0, 0, 5'd4, 1, "R6 sra pos");
    drive(4'd9, 32'h0, 32'h12345678, 16'hffff, 1, 5'd8, 1, "R6 srl imm ignored");
    // R7 upper load
    drive(4'd11, 32'hffffffff, 32'hffffffff, 16'h1234, 0, 0, 1, "R7 lui");
    drive(4'd11, 32'h0, 32'h0, 16'h8000, 1, 0, 1, "R7 lui imm sel");
    // R8 undefined codes
    for (int c = 12; c < 16; c++)
      drive(4'(c), 32'hffffffff, 32'h1, 16'hffff, 0, 5'd3, 1, "R8 undefined");
    // mixed sweep
    lfsr = 32'hace1_2345;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; x = lfsr;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; y = lfsr;
      drive(4'(i % 16), x, y, y[31:16], x[0], y[4:0], y[7], "R2 sweep");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule